// File: doc/BRIEF.md
# High-Resolution PWM Edge Controller

This block produces an up-counting PWM waveform with coarse edges set by a period and a compare register. For each edge it also produces a fine delay code, which an external step-delay line uses to move that edge by a fraction of a clock. A counter runs from zero up to the period value and then wraps. The output rises at zero and falls at the compare match. An 8-bit fraction is scaled by the number of delay steps that fit in one clock, and the result goes out as the fine code of the selected edge, together with a one-cycle strobe.

A mode field selects which edges get fine placement: the rising edge, the falling edge, both edges, or neither. Rising-only and falling-only modes serve duty-cycle control and take their fraction from the compare fraction register. Both-edge mode serves phase-shift control and takes its fraction from the phase fraction register. The coarse compare value and its fraction share a shadow register pair. That pair loads into the active registers on a selectable event. The phase fraction always loads directly.

Top module: `hrpwm_edge_ctl`

## Requirements
- R1: `cfg_edge_mode` selects the edges that carry fine codes: 0 = rising only, 1 = falling only, 2 = both, 3 = none. Strobes appear only on the selected edges.
- R2: In modes 0 and 1 the fraction comes from the active compare fraction. In mode 2 it comes from the phase fraction.
- R3: The fine code equals (fraction × `step_scale`) >> 8, limited to `step_scale`.
- R4: A strobe lasts one cycle and is issued only when its code is nonzero. Each code output reads 0 in every cycle its strobe is low.
- R5: The counter counts 0,1,…,period and then returns to 0. `pwm_out` is registered: it goes high one cycle after the counter reads 0, and low one cycle after the counter equals the active compare value.
- R6: An active compare of 0 holds `pwm_out` low. An active compare above the period holds it high. A suppressed edge issues no strobe.
- R7: `cfg_load_sel` selects when the compare value and the compare fraction move from shadow to active, and they always move together: 0 = when the counter reads 0, 1 = when the counter equals the period, 2 or 3 = directly on the write.
- R8: A phase fraction write takes effect in the next cycle for every `cfg_load_sel` value.
- R9: A period write takes effect in the next cycle. If the counter is at or above the period, it returns to 0 on the next cycle.
- R10: After reset, `pwm_out`, both codes and both strobes are 0, and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_edge_mode | input | 2 | Fine-placement edge select |
| cfg_load_sel | input | 2 | Compare load event select |
| step_scale | input | SCALE_W | Delay steps per clock |
| prd_wr | input | 1 | Period write strobe |
| prd_data | input | CNT_W | Period value |
| cmp_wr | input | 1 | Compare and compare-fraction write strobe |
| cmp_data | input | CNT_W | Coarse compare value |
| cmp_frac_data | input | FRAC_W | Compare fraction |
| phs_wr | input | 1 | Phase fraction write strobe |
| phs_frac_data | input | FRAC_W | Phase fraction |
| pwm_out | output | 1 | Coarse PWM output |
| rise_code | output | SCALE_W | Rising-edge fine delay code |
| rise_stb | output | 1 | Rising-edge code strobe |
| fall_code | output | SCALE_W | Falling-edge fine delay code |
| fall_stb | output | 1 | Falling-edge code strobe |

## Verification
The bench builds the block with its default widths: a 16-bit counter, an 8-bit fraction and an 8-bit scale. The programmed periods are short, so many full PWM cycles fit into each scenario. With these widths, a compare value near the top of the 16-bit range can be placed above the period to force a constant-high output. A scale of 255 with a fraction of 255 drives the largest fine code. Small fractions make the scaled code round down to zero, which reaches the strobe-suppression case.

// File: rtl/hrpwm_edge_ctl.sv
module hrpwm_edge_ctl #(
  parameter int CNT_W   = 16,
  parameter int FRAC_W  = 8,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_edge_mode,
  input  logic [1:0]         cfg_load_sel,
  input  logic [SCALE_W-1:0] step_scale,
  input  logic               prd_wr,
  input  logic [CNT_W-1:0]   prd_data,
  input  logic               cmp_wr,
  input  logic [CNT_W-1:0]   cmp_data,
  input  logic [FRAC_W-1:0]  cmp_frac_data,
  input  logic               phs_wr,
  input  logic [FRAC_W-1:0]  phs_frac_data,
  output logic               pwm_out,
  output logic [SCALE_W-1:0] rise_code,
  output logic               rise_stb,
  output logic [SCALE_W-1:0] fall_code,
  output logic               fall_stb
);
  localparam logic [1:0] EM_RISE = 2'd0;
  localparam logic [1:0] EM_FALL = 2'd1;
  localparam logic [1:0] EM_BOTH = 2'd2;
  localparam logic [1:0] LD_ZERO = 2'd0;
  localparam logic [1:0] LD_PRD  = 2'd1;
  localparam int PROD_W = FRAC_W + SCALE_W;

  logic [CNT_W-1:0]  cnt, prd_act, cmp_act, cmp_sh;
  logic [FRAC_W-1:0] cfrac_act, cfrac_sh, phs_act;

  wire at_zero  = (cnt == '0);
  wire at_prd   = (cnt == prd_act);
  wire wrap     = (cnt >= prd_act);
  wire shadowed = ~cfg_load_sel[1];
  wire load_evt = ((cfg_load_sel == LD_ZERO) & at_zero) |
                  ((cfg_load_sel == LD_PRD) & at_prd);

  wire [FRAC_W-1:0]  frac   = (cfg_edge_mode == EM_BOTH) ? phs_act : cfrac_act;
  wire [PROD_W-1:0]  prod   = PROD_W'(frac) * PROD_W'(step_scale);
  wire [SCALE_W-1:0] scaled = SCALE_W'(prod >> FRAC_W);
  wire [SCALE_W-1:0] code   = (scaled > step_scale) ? step_scale : scaled;
  wire               code_nz = (code != '0);

  wire force_low  = (cmp_act == '0);
  wire force_high = ~force_low & (cmp_act > prd_act);
  wire live       = ~force_low & ~force_high;
  wire hit_rise   = live & at_zero;
  wire hit_fall   = live & (cnt == cmp_act);
  wire rise_on    = (cfg_edge_mode == EM_RISE) | (cfg_edge_mode == EM_BOTH);
  wire fall_on    = (cfg_edge_mode == EM_FALL) | (cfg_edge_mode == EM_BOTH);
  wire rise_go    = hit_rise & rise_on & code_nz;
  wire fall_go    = hit_fall & fall_on & code_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      prd_act <= '0;
      phs_act <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (prd_wr) prd_act <= prd_data;
      if (phs_wr) phs_act <= phs_frac_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_sh    <= '0;
      cfrac_sh  <= '0;
      cmp_act   <= '0;
      cfrac_act <= '0;
    end else begin
      if (cmp_wr) begin
        cmp_sh   <= cmp_data;
        cfrac_sh <= cmp_frac_data;
      end
      if (!shadowed) begin
        if (cmp_wr) begin
          cmp_act   <= cmp_data;
          cfrac_act <= cmp_frac_data;
        end
      end else if (load_evt) begin
        cmp_act   <= cmp_sh;
        cfrac_act <= cfrac_sh;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out   <= 1'b0;
      rise_stb  <= 1'b0;
      fall_stb  <= 1'b0;
      rise_code <= '0;
      fall_code <= '0;
    end else begin
      if (force_low)       pwm_out <= 1'b0;
      else if (force_high) pwm_out <= 1'b1;
      else if (hit_rise)   pwm_out <= 1'b1;
      else if (hit_fall)   pwm_out <= 1'b0;
      rise_stb  <= rise_go;
      fall_stb  <= fall_go;
      rise_code <= rise_go ? code : '0;
      fall_code <= fall_go ? code : '0;
    end
  end

  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_act == '0) |=> !pwm_out); // R6
  AST_BIG_CMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_act != '0) && (cmp_act > prd_act)) |=> pwm_out); // R6
  AST_RISE_STB_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> pwm_out); // R5
  AST_FALL_STB_WITH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !pwm_out); // R5
  AST_NO_RISE_IN_FALL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> ($past(cfg_edge_mode) != EM_FALL)); // R1
  AST_CODE_WITHIN_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (rise_code <= $past(step_scale))); // R3
  AST_STB_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb |-> (fall_code != '0)) and (!fall_stb |-> (fall_code == '0))); // R4
  AST_CNT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > prd_act) |=> (cnt == '0)); // R9
endmodule

// File: tb/tb_hrpwm_edge_ctl.sv
module tb_hrpwm_edge_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_edge_mode = 2'd0, cfg_load_sel = 2'd2;
  logic [7:0] step_scale = 8'd0;
  logic prd_wr = 0, cmp_wr = 0, phs_wr = 0;
  logic [15:0] prd_data = 0, cmp_data = 0;
  logic [7:0] cmp_frac_data = 0, phs_frac_data = 0;
  logic pwm_out, rise_stb, fall_stb;
  logic [7:0] rise_code, fall_code;

  hrpwm_edge_ctl dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit live_cmp = 0, done = 0;
  string cur_req = "R10";

  int m_cnt = 0, m_prd = 0, m_cmp = 0, m_csh = 0, m_cf = 0, m_cfsh = 0, m_phs = 0;
  int m_out = 0, m_rc = 0, m_rs = 0, m_fc = 0, m_fs = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t: actual %0d expected %0d", tag, cur_req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_cmp = 0; m_csh = 0; m_cf = 0; m_cfsh = 0; m_phs = 0;
      m_out = 0; m_rc = 0; m_rs = 0; m_fc = 0; m_fs = 0;
    end else begin
      int frac, code, md;
      bit lo, hi, r, f, evt;
      md = int'(cfg_edge_mode);
      frac = (md == 2) ? m_phs : m_cf;
      code = (frac * int'(step_scale)) / 256;
      if (code > int'(step_scale)) code = int'(step_scale);
      lo = (m_cmp == 0);
      hi = !lo && (m_cmp > m_prd);
      r = !lo && !hi && (m_cnt == 0);
      f = !lo && !hi && (m_cnt == m_cmp);
      if (lo) m_out = 0; else if (hi) m_out = 1; else if (r) m_out = 1; else if (f) m_out = 0;
      m_rs = (r && (md == 0 || md == 2) && code != 0) ? 1 : 0;
      m_fs = (f && (md == 1 || md == 2) && code != 0) ? 1 : 0;
      m_rc = m_rs ? code : 0;
      m_fc = m_fs ? code : 0;
      evt = (cfg_load_sel == 0 && m_cnt == 0) || (cfg_load_sel == 1 && m_cnt == m_prd);
      if (cfg_load_sel >= 2) begin
        if (cmp_wr) begin m_cmp = int'(cmp_data); m_cf = int'(cmp_frac_data); end
      end else if (evt) begin
        m_cmp = m_csh; m_cf = m_cfsh;
      end
      if (cmp_wr) begin m_csh = int'(cmp_data); m_cfsh = int'(cmp_frac_data); end
      if (phs_wr) m_phs = int'(phs_frac_data);
      m_cnt = (m_cnt >= m_prd) ? 0 : m_cnt + 1;
      if (prd_wr) m_prd = int'(prd_data);
    end
  end

  always @(negedge clk) begin
    if (live_cmp) begin
      chk("R5", pwm_out, m_out);
      chk("R1", rise_stb, m_rs);
      chk("R4", fall_stb, m_fs);
      chk("R3", rise_code, m_rc);
      chk("R2", fall_code, m_fc);
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cmp(int c, int fr);
    cmp_data = 16'(c); cmp_frac_data = 8'(fr); cmp_wr = 1;
    @(negedge clk); cmp_wr = 0;
  endtask

  task automatic wr_prd(int p);
    prd_data = 16'(p); prd_wr = 1;
    @(negedge clk); prd_wr = 0;
  endtask

  task automatic wr_phs(int p);
    phs_frac_data = 8'(p); phs_wr = 1;
    @(negedge clk); phs_wr = 0;
  endtask

  initial begin
    run(3);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R10";
    chk("R10", pwm_out, 0); chk("R10", rise_stb, 0); chk("R10", fall_stb, 0);
    chk("R10", rise_code, 0); chk("R10", fall_code, 0);
    live_cmp = 1;

    cur_req = "R5";
    step_scale = 8'd56; cfg_load_sel = 2'd2; cfg_edge_mode = 2'd0;
    wr_prd(9); wr_cmp(4, 128); run(30);
    cur_req = "R1"; cfg_edge_mode = 2'd1; run(25);
    cur_req = "R8"; wr_phs(200); cfg_edge_mode = 2'd2; run(25);
    cur_req = "R2"; cfg_load_sel = 2'd0; wr_phs(90); run(22);
    cur_req = "R1"; cfg_edge_mode = 2'd3; run(22);
    cur_req = "R4"; cfg_edge_mode = 2'd2; wr_phs(1); run(22);
    cfg_edge_mode = 2'd0; cfg_load_sel = 2'd2; wr_cmp(6, 3); run(22);
    cur_req = "R7"; cfg_load_sel = 2'd0; wr_cmp(7, 64); run(25);
    cfg_load_sel = 2'd1; cfg_edge_mode = 2'd1; wr_cmp(2, 160); run(25);
    cfg_load_sel = 2'd3; wr_cmp(8, 250); run(22);
    cur_req = "R6"; cfg_edge_mode = 2'd2; wr_cmp(0, 100); run(22);
    wr_cmp(16'hFFF0, 100); run(22);
    cur_req = "R9"; wr_cmp(5, 100); wr_prd(20); run(15); wr_prd(3); run(20);
    cur_req = "R3"; step_scale = 8'd255; cfg_edge_mode = 2'd0; wr_cmp(2, 255); run(20);
    cfg_edge_mode = 2'd2; wr_phs(255); run(20);
    step_scale = 8'd1; wr_phs(200); run(12);
    cur_req = "R10"; rst_n = 0; live_cmp = 0; run(2);
    chk("R10", pwm_out, 0); chk("R10", rise_code, 0); chk("R10", fall_stb, 0);
    rst_n = 1; live_cmp = 1; run(10);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog (%s): actual hung expected finished", cur_req);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule